// File: doc/BRIEF.md
# Stereo Digital Volume Stage with Selectable Change Policy

This block scales a stream of signed 24-bit stereo samples by a per-channel attenuation set in 1 dB steps. An extra fixed gain of +20 dB is available, and each channel has its own mute. Every scaled result is clipped to the signed 24-bit range, so it never wraps.

A new attenuation target does not take effect straight away. It follows one of four change policies chosen by a 2-bit field:
- It can be applied at once.
- It can wait for the channel's next zero crossing.
- It can walk toward the target one dB at a time on a fixed sample cadence.
- It can walk one dB at a time, stepping only at zero crossings.

The zero-crossing policies have a timeout. If no crossing arrives in time, the change happens anyway. A busy flag for each channel shows that its applied level has not yet reached the target.

The stage is driven by a sample-valid strobe. Each strobe yields one registered output pair on the next clock.

Top module: `dvol_stage`

## Requirements
- R1: On a cycle with `in_valid` high, the outputs (valid on the next cycle with `out_valid` high) are sat(floor(x * b * F(a) / 65536)). Here x is the input sample, b is 10 when boost is set and 1 otherwise, and a is the channel's applied attenuation before that strobe. F(0)=65536 and F(k)=floor(F(k-1)*58409/65536). Outputs hold their value between strobes.
- R2: Results above 8388607 give 8388607, and results below -8388608 give -8388608.
- R3: When a channel's mute is set, its output for that strobe is 0. Its applied attenuation keeps following the change policy while muted.
- R4: Change field 2'b00 (immediate): at each strobe the applied attenuation becomes the target.
- R5: Change field 2'b01 (zero cross): the applied attenuation jumps to the target at a strobe whose sample sign bit differs from the previous sample of the same channel. The sign before the first sample counts as non-negative. Each channel detects its own crossings.
- R6: In fields 2'b01 and 2'b11, while applied differs from target, the ZC_TMO-th consecutive strobe without a crossing counts as a crossing. The count restarts after every crossing or change, and whenever applied equals target.
- R7: Change field 2'b10 (soft ramp, the policy of choice after reset): on tick strobes, the applied attenuation moves one dB toward the target. Strobe n counts from 0 after reset, and it is a tick when n mod RAMP_N equals RAMP_N-1.
- R8: Change field 2'b11 (soft ramp on crossings): each crossing or timeout strobe moves the applied attenuation one dB toward the target.
- R9: The busy flag of each channel is registered. One cycle after any edge, it equals (applied attenuation != target).
- R10: After reset, the outputs, `out_valid` and the busy flags are 0, and the applied attenuation is 0 dB.
- R11: The two channels keep separate targets, mutes, boosts, crossing detection and timeouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| left_att | input | 6 | Left target attenuation in dB |
| right_att | input | 6 | Right target attenuation in dB |
| left_mute | input | 1 | Left mute |
| right_mute | input | 1 | Right mute |
| left_boost | input | 1 | Left +20 dB gain |
| right_boost | input | 1 | Right +20 dB gain |
| chg_mode | input | 2 | Change policy, 00 now, 01 zero cross, 10 ramp, 11 ramp on crossings |
| out_valid | output | 1 | Output pair valid |
| left_out | output | 24 | Scaled left sample |
| right_out | output | 24 | Scaled right sample |
| left_busy | output | 1 | Left level still moving |
| right_busy | output | 1 | Right level still moving |

## Verification
A scaled sample appears one clock after its strobe edge. That sample uses the attenuation that was in force before the strobe, and the new attenuation from that strobe shows up in the following sample. The busy flag settles one clock after the strobe. The bench drives each strobe on a falling edge and reads outputs and busy flags on the next falling edge, half a period after the register edge. Its reference model steps its attenuation, its crossing memory, its timeout count and its strobe index in the same strobe order.

// File: rtl/dvol_pkg.sv
package dvol_pkg;

  typedef enum logic [1:0] {
    CHG_NOW     = 2'b00,
    CHG_ZC      = 2'b01,
    CHG_RAMP    = 2'b10,
    CHG_RAMP_ZC = 2'b11
  } chg_mode_e;

  // Linear factor for k dB of attenuation, with 'frac' fractional bits.
  // 58409/65536 approximates one dB down.
  function automatic longint db_factor(int k, int frac);
    longint f;
    f = longint'(1) << frac;
    for (int i = 0; i < k; i++) f = (f * 58409) >> 16;
    return f;
  endfunction

endpackage

// File: rtl/dvol_gain_rom.sv
module dvol_gain_rom #(
  parameter int ATT_W  = 6,
  parameter int FRAC   = 16,
  parameter int COEF_W = FRAC + 1
) (
  input  logic [ATT_W-1:0]  addr,
  output logic [COEF_W-1:0] coef
);
  localparam int DEPTH = 1 << ATT_W;

  logic [COEF_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl[g] = COEF_W'(dvol_pkg::db_factor(g, FRAC));
  end

  assign coef = tbl[addr];
endmodule

// File: rtl/dvol_scaler.sv
module dvol_scaler #(
  parameter int SAMP_W = 24,
  parameter int FRAC   = 16,
  parameter int COEF_W = FRAC + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] x,
  input  logic [COEF_W-1:0] coef,
  input  logic              boost,
  input  logic              mute,
  output logic [SAMP_W-1:0] y
);
  localparam int BW = SAMP_W + 4;
  localparam int PW = BW + COEF_W + 1;
  localparam logic signed [PW-1:0] SMAX = {{(PW-SAMP_W+1){1'b0}}, {(SAMP_W-1){1'b1}}};
  localparam logic signed [PW-1:0] SMIN = {{(PW-SAMP_W+1){1'b1}}, {(SAMP_W-1){1'b0}}};

  logic signed [BW-1:0] xe, bx;
  logic signed [PW-1:0] prod, q;
  logic [SAMP_W-1:0]    sat;

  always_comb begin
    xe   = {{(BW-SAMP_W){x[SAMP_W-1]}}, x};
    bx   = boost ? (xe <<< 3) + (xe <<< 1) : xe;
    prod = PW'(bx) * PW'($signed({1'b0, coef}));
    q    = prod >>> FRAC;
    if (q > SMAX)      sat = SMAX[SAMP_W-1:0];
    else if (q < SMIN) sat = SMIN[SAMP_W-1:0];
    else               sat = q[SAMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)           y <= '0;
    else if (in_valid) y <= mute ? '0 : sat;
  end

  // R1
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !x[SAMP_W-1]) |=> !y[SAMP_W-1]);
endmodule

// File: rtl/dvol_gain_ctrl.sv
module dvol_gain_ctrl
  import dvol_pkg::*;
#(
  parameter int ATT_W  = 6,
  parameter int ZC_TMO = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             samp_neg,
  input  logic [ATT_W-1:0] tgt,
  input  logic [1:0]       mode,
  input  logic             tick,
  output logic [ATT_W-1:0] applied,
  output logic             busy
);
  localparam int WCW = $clog2(ZC_TMO + 1);

  logic           prev_neg;
  logic [WCW-1:0] wcnt, wnxt;
  logic [ATT_W-1:0] nxt, stepped;
  logic           diff, zc, evt;

  always_comb begin
    diff    = (applied != tgt);
    zc      = (samp_neg != prev_neg);
    evt     = zc || (wcnt == WCW'(ZC_TMO - 1));
    stepped = (applied < tgt) ? applied + 1'b1 : applied - 1'b1;
    nxt     = applied;
    wnxt    = wcnt;
    if (in_valid) begin
      case (mode)
        CHG_NOW: begin
          nxt  = tgt;
          wnxt = '0;
        end
        CHG_ZC: begin
          if (!diff)    wnxt = '0;
          else if (evt) begin nxt = tgt; wnxt = '0; end
          else          wnxt = wcnt + 1'b1;
        end
        CHG_RAMP: begin
          wnxt = '0;
          if (diff && tick) nxt = stepped;
        end
        default: begin
          if (!diff)    wnxt = '0;
          else if (evt) begin nxt = stepped; wnxt = '0; end
          else          wnxt = wcnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      applied  <= '0;
      wcnt     <= '0;
      prev_neg <= 1'b0;
      busy     <= 1'b0;
    end else begin
      applied <= nxt;
      wcnt    <= wnxt;
      busy    <= (nxt != tgt);
      if (in_valid) prev_neg <= samp_neg;
    end
  end

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(applied));

  // R4
  now_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == CHG_NOW) |=> applied == $past(tgt));

  // R5
  zc_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == CHG_ZC && !evt) |=> $stable(applied));

  // R7
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[1]) |=> (applied == $past(applied)) ||
      (applied == $past(applied) + 1'b1) || (applied + 1'b1 == $past(applied)));
endmodule

// File: rtl/dvol_stage.sv
module dvol_stage #(
  parameter int SAMP_W = 24,
  parameter int ATT_W  = 6,
  parameter int FRAC   = 16,
  parameter int RAMP_N = 4,
  parameter int ZC_TMO = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] left_in,
  input  logic [SAMP_W-1:0] right_in,
  input  logic [ATT_W-1:0]  left_att,
  input  logic [ATT_W-1:0]  right_att,
  input  logic              left_mute,
  input  logic              right_mute,
  input  logic              left_boost,
  input  logic              right_boost,
  input  logic [1:0]        chg_mode,
  output logic              out_valid,
  output logic [SAMP_W-1:0] left_out,
  output logic [SAMP_W-1:0] right_out,
  output logic              left_busy,
  output logic              right_busy
);
  localparam int COEF_W = FRAC + 1;
  localparam int TCW    = $clog2(RAMP_N + 1);
  localparam int NCH    = 2;

  logic [TCW-1:0]    tcnt;
  logic              tick;
  logic [SAMP_W-1:0] ch_in   [NCH];
  logic [SAMP_W-1:0] ch_out  [NCH];
  logic [ATT_W-1:0]  ch_tgt  [NCH];
  logic [ATT_W-1:0]  ch_app  [NCH];
  logic [COEF_W-1:0] ch_coef [NCH];
  logic [NCH-1:0]    ch_mute, ch_boost, ch_busy;

  assign ch_in[0]  = left_in;   assign ch_in[1]  = right_in;
  assign ch_tgt[0] = left_att;  assign ch_tgt[1] = right_att;
  assign ch_mute   = {right_mute, left_mute};
  assign ch_boost  = {right_boost, left_boost};
  assign left_out  = ch_out[0];
  assign right_out = ch_out[1];
  assign left_busy  = ch_busy[0];
  assign right_busy = ch_busy[1];

  assign tick = (tcnt == TCW'(RAMP_N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) tcnt <= tick ? '0 : tcnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dvol_gain_ctrl #(.ATT_W(ATT_W), .ZC_TMO(ZC_TMO)) i_ctrl (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .samp_neg(ch_in[c][SAMP_W-1]), .tgt(ch_tgt[c]), .mode(chg_mode),
      .tick(tick), .applied(ch_app[c]), .busy(ch_busy[c]));

    dvol_gain_rom #(.ATT_W(ATT_W), .FRAC(FRAC), .COEF_W(COEF_W)) i_rom (
      .addr(ch_app[c]), .coef(ch_coef[c]));

    dvol_scaler #(.SAMP_W(SAMP_W), .FRAC(FRAC), .COEF_W(COEF_W)) i_scl (
      .clk(clk), .rst(rst), .in_valid(in_valid), .x(ch_in[c]),
      .coef(ch_coef[c]), .boost(ch_boost[c]), .mute(ch_mute[c]), .y(ch_out[c]));
  end

  // R3
  left_mute_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && left_mute) |=> left_out == '0);

  // R3
  right_mute_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && right_mute) |=> right_out == '0);
endmodule

// File: tb/test_dvol_stage.sv
`timescale 1ns/1ps
module test_dvol_stage;
  localparam int RAMP = 4;
  localparam int TMO  = 16;
  localparam time TCK = 20ns;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [23:0] left_in = '0, right_in = '0;
  logic [5:0]  left_att = '0, right_att = '0;
  logic left_mute = 1'b0, right_mute = 1'b0, left_boost = 1'b0, right_boost = 1'b0;
  logic [1:0] chg_mode = 2'b10;
  logic out_valid, left_busy, right_busy;
  logic [23:0] left_out, right_out;

  int n_chk = 0, n_bad = 0, strobe_n = 0;
  int m_app [2];
  int m_w   [2];
  bit m_prev [2];

  always #(TCK/2) clk = ~clk;

  dvol_stage #(.RAMP_N(RAMP), .ZC_TMO(TMO)) i_dvol_stage (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint fac(int k);
    longint f = 65536;
    for (int i = 0; i < k; i++) f = (f * 58409) / 65536;
    return f;
  endfunction

  function automatic longint scale(longint x, int a, bit bst, bit mt);
    longint p;
    if (mt) return 0;
    p = (x * (bst ? 10 : 1) * fac(a)) >>> 16;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return p;
  endfunction

  task automatic model_step(int c, int tgt, bit neg, bit tk);
    bit evt;
    int stp;
    evt = (neg != m_prev[c]) || (m_w[c] == TMO - 1);
    stp = (m_app[c] < tgt) ? m_app[c] + 1 : m_app[c] - 1;
    case (chg_mode)
      2'b00: begin m_app[c] = tgt; m_w[c] = 0; end
      2'b10: begin m_w[c] = 0; if (m_app[c] != tgt && tk) m_app[c] = stp; end
      default: begin
        if (m_app[c] == tgt) m_w[c] = 0;
        else if (evt) begin m_app[c] = (chg_mode == 2'b01) ? tgt : stp; m_w[c] = 0; end
        else m_w[c]++;
      end
    endcase
    m_prev[c] = neg;
  endtask

  task automatic send(input longint l, input longint r, input string req);
    longint el, er;
    bit tk;
    el = scale(l, m_app[0], left_boost, left_mute);
    er = scale(r, m_app[1], right_boost, right_mute);
    tk = (strobe_n % RAMP) == RAMP - 1;
    strobe_n++;
    model_step(0, int'(left_att), l < 0, tk);
    model_step(1, int'(right_att), r < 0, tk);
    left_in = l[23:0]; right_in = r[23:0]; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, req, out_valid, 1);
    chk(longint'($signed(left_out)) == el, req, longint'($signed(left_out)), el);
    chk(longint'($signed(right_out)) == er, req, longint'($signed(right_out)), er);
    chk(left_busy == (m_app[0] != int'(left_att)), {req, "/R9"}, left_busy, m_app[0] != int'(left_att));
    chk(right_busy == (m_app[1] != int'(right_att)), {req, "/R9"}, right_busy, m_app[1] != int'(right_att));
  endtask

  task automatic t_reset();
    chk(out_valid == 0 && left_busy == 0 && right_busy == 0, "R10", out_valid, 0);
    chk(left_out == 0 && right_out == 0, "R10", left_out, 0);
    send(1000000, -1000000, "R10 unity gain after reset");
  endtask

  task automatic t_immediate();
    chg_mode = 2'b00; left_att = 6; right_att = 0;
    send(123456, -654321, "R4");
    send(-4000000, 4000000, "R4/R1");
    left_att = 20; right_att = 63;
    send(8000000, -8000000, "R4/R11");
    send(7, -7, "R1");
    repeat (3) @(negedge clk);
    chk(longint'($signed(left_out)) == scale(7, 20, 0, 0), "R1 hold", $signed(left_out), scale(7, 20, 0, 0));
  endtask

  task automatic t_saturate();
    chg_mode = 2'b00; left_att = 0; right_att = 0; left_boost = 1; right_boost = 1;
    send(8388607, -8388608, "R2");
    send(1000000, -1000000, "R2");
    send(300000, -300000, "R1 boost");
    left_att = 10; right_boost = 0;
    send(-838860, 838860, "R2/R11");
    send(5000, 5000, "R1 boost at 10 dB");
    left_boost = 0;
  endtask

  task automatic t_mute();
    chg_mode = 2'b00; left_mute = 1; left_att = 12; right_att = 3;
    send(2000000, 2000000, "R3");
    left_att = 30;
    send(-2000000, -2000000, "R3 gain tracks");
    left_mute = 0;
    send(2000000, 2000000, "R3 after unmute");
  endtask

  task automatic t_zero_cross();
    chg_mode = 2'b00; left_att = 0; right_att = 0;
    send(100, 100, "R5 setup");
    chg_mode = 2'b01; left_att = 9; right_att = 4;
    send(200000, 200000, "R5 no crossing");
    send(300000, 300000, "R5 no crossing");
    send(-300000, 400000, "R5/R11 left crosses");
    send(-200000, -500000, "R5 right crosses");
    send(100000, 100000, "R5 settled");
  endtask

  task automatic t_timeout();
    chg_mode = 2'b01; left_att = 25; right_att = 4;
    for (int i = 0; i < TMO + 2; i++) send(50000 + i, -50000, "R6");
  endtask

  task automatic t_ramp();
    chg_mode = 2'b00; left_att = 0; right_att = 10;
    send(1000, 1000, "R7 setup");
    chg_mode = 2'b10; left_att = 10; right_att = 0;
    for (int i = 0; i < 46; i++) send((i % 3 == 0) ? -3000000 : 3000000, 2500000, "R7");
  endtask

  task automatic t_ramp_zc();
    chg_mode = 2'b11; left_att = 5; right_att = 15;
    for (int i = 0; i < 14; i++) send((i % 2) ? 700000 : -700000, 900000, "R8");
    for (int i = 0; i < TMO * 2 + 4; i++) send(600000, 900000, "R8/R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_saturate();
    t_mute();
    t_zero_cross();
    t_timeout();
    t_ramp();
    t_ramp_zc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule